// File: doc/BRIEF.md
# UART Automatic Flow Control Engine

This block decides, for one UART channel, when the local transmitter may send and when the remote end must be told to pause. It has two mechanisms that can be used together. The hardware one compares the receive FIFO fill level against a high and a low threshold to drive the request-to-send line, and watches the clear-to-send line to pause the local transmitter. The software one places Xoff/Xon characters into the outgoing stream at the same thresholds. It also recognises incoming Xoff/Xon characters, either single characters or ordered pairs, and drops them from the received data.

The transmitter samples `tx_hold` only between characters. A character that is already being shifted out therefore always completes, including its stop bit, before the pause takes effect. Only FIFO data is paused by `tx_hold`; inserted flow-control characters are not. The insert path is a valid/ready stream. Once `ins_valid` is high, it stays high and `ins_data` stays unchanged until a cycle in which `ins_ready` is also high; that cycle transfers the character. The transmitter must give this stream priority over its next FIFO byte. The receive path has no back-pressure: `rx_drop` is valid in the same cycle as `rx_valid` and is used to gate the FIFO write.

All modem pins are active low (0 means asserted or clear-to-send). Thresholds are unsigned levels from 1 to 128.

Top module: `flow_ctrl_engine`

## Requirements
- R1: With `cfg_auto_cts` set and no remap, `cts_n` = 1 raises `tx_hold` after two clock edges (synchroniser), and `cts_n` = 0 clears it after two edges.
- R2: With `cfg_swap_dsr_dtr` = 1, the clear-to-send function is taken from `dsr_n` and `cts_n` is ignored. The request-to-send function then drives `dtr_n`, and `rts_n` follows `man_rts_n`. With the remap off, `dtr_n` follows `man_dtr_n`.
- R3: With `cfg_auto_rts` set, the request-to-send output goes to 1 on the edge after `rx_level` >= `cfg_hi_thr`. It goes back to 0 on the edge after `rx_level` <= `cfg_lo_thr`, and holds its value at levels in between. With `cfg_auto_rts` clear, that output follows the manual input.
- R4: With `cfg_sw_tx_en` set and no Xoff outstanding, `rx_level` >= `cfg_hi_thr` issues one Xoff on the insert stream and marks Xoff as outstanding. No further Xoff is issued while the level stays high.
- R5: While an Xoff is outstanding, `rx_level` <= `cfg_lo_thr` issues one Xon and clears the outstanding mark. Intermediate levels issue nothing.
- R6: With `cfg_sw_dual` = 0 the inserted Xoff/Xon is `cfg_xoff1`/`cfg_xon1`. With `cfg_sw_dual` = 1 it is the pair `cfg_xoff1` then `cfg_xoff2`, or `cfg_xon1` then `cfg_xon2`.
- R7: `ins_valid` and `ins_data` stay stable while `ins_ready` is 0, and insertion is not blocked by `tx_hold`.
- R8: With `cfg_sw_rx_en` set and `cfg_sw_dual` = 0, a received `cfg_xoff1` raises `tx_hold` on the next edge and a received `cfg_xon1` clears it. Both characters raise `rx_drop` in their own cycle.
- R9: With `cfg_sw_dual` = 1, `tx_hold` is raised only by `cfg_xoff1` immediately followed by `cfg_xoff2`, and cleared only by `cfg_xon1` immediately followed by `cfg_xon2`. Every character of a pair is dropped, and so is any `cfg_xoff1`/`cfg_xon1`.
- R10: In dual mode, any other character passes with `rx_drop` = 0 and cancels a half-received pair. A second character of a pair that arrives without its first is passed as data.
- R11: A `rx_flush` pulse clears the outstanding-Xoff mark, so no Xon follows even when the level then drops to or below the low threshold.
- R12: With `cfg_auto_cts` clear, `cts_n` has no effect on `tx_hold`. With `cfg_sw_rx_en` clear, no character is dropped and none changes `tx_hold`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_auto_cts | input | 1 | Pause transmitter from the clear-to-send input |
| cfg_auto_rts | input | 1 | Drive request-to-send from FIFO thresholds |
| cfg_swap_dsr_dtr | input | 1 | Move flow control onto `dsr_n` / `dtr_n` |
| cfg_sw_rx_en | input | 1 | Recognise and drop received Xon/Xoff |
| cfg_sw_tx_en | input | 1 | Insert Xoff/Xon at thresholds |
| cfg_sw_dual | input | 1 | Use two-character Xon/Xoff |
| cfg_hi_thr | input | LVL_W | High threshold (1..128) |
| cfg_lo_thr | input | LVL_W | Low threshold (1..128) |
| cfg_xon1 | input | CHAR_W | First Xon character |
| cfg_xon2 | input | CHAR_W | Second Xon character |
| cfg_xoff1 | input | CHAR_W | First Xoff character |
| cfg_xoff2 | input | CHAR_W | Second Xoff character |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_flush | input | 1 | Receive FIFO clear pulse |
| rx_valid | input | 1 | Received character present |
| rx_data | input | CHAR_W | Received character |
| rx_drop | output | 1 | Do not write this character into the FIFO |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| man_rts_n | input | 1 | Manual level for `rts_n` |
| man_dtr_n | input | 1 | Manual level for `dtr_n` |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| tx_hold | output | 1 | Transmitter must not start a FIFO character |
| ins_valid | output | 1 | Flow-control character offered |
| ins_ready | input | 1 | Transmitter accepts the offered character |
| ins_data | output | CHAR_W | Flow-control character |

## Verification
The threshold logic is driven with a level sequence that rises to the high mark, stops in the hysteresis band and falls to the low mark. This separates a correct hysteresis from a plain comparator and shows that each Xoff or Xon is issued exactly once. The receive matcher gets four patterns: isolated single characters, complete ordered pairs, pairs broken by a data byte, and a second character arriving alone. Together these distinguish true sequence matching from per-character matching. Stalling `ins_ready` while the remote side has paused the transmitter shows that the insert stream keeps its data and is not blocked by `tx_hold`. A flush between an Xoff and the low level shows that the outstanding mark is actually cleared.

// File: rtl/flow_ctrl_pkg.sv
package flow_ctrl_pkg;
  typedef enum logic [1:0] {INS_IDLE, INS_FIRST, INS_SECOND} ins_state_t;
  typedef enum logic [1:0] {PEND_NONE, PEND_XON, PEND_XOFF} pend_t;
endpackage

// File: rtl/fc_sync.sv
module fc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= d;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end
  endgenerate
  assign q = sh[STAGES-1];
endmodule

// File: rtl/fc_rx_match.sv
module fc_rx_match
  import flow_ctrl_pkg::*;
#(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dual,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  input  logic [CHAR_W-1:0] xon1,
  input  logic [CHAR_W-1:0] xon2,
  input  logic [CHAR_W-1:0] xoff1,
  input  logic [CHAR_W-1:0] xoff2,
  output logic              drop,
  output logic              stop
);
  pend_t pend;
  logic  hit_on1, hit_off1, done_off, done_on;

  assign hit_on1  = (rx_data == xon1);
  assign hit_off1 = (rx_data == xoff1);
  assign done_off = dual && (pend == PEND_XOFF) && (rx_data == xoff2);
  assign done_on  = dual && (pend == PEND_XON)  && (rx_data == xon2);

  always_comb begin
    drop = 1'b0;
    if (en && rx_valid)
      drop = hit_on1 || hit_off1 || done_off || done_on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop <= 1'b0;
      pend <= PEND_NONE;
    end else if (!en) begin
      stop <= 1'b0;
      pend <= PEND_NONE;
    end else if (rx_valid) begin
      if (!dual) begin
        pend <= PEND_NONE;
        if (hit_off1)     stop <= 1'b1;
        else if (hit_on1) stop <= 1'b0;
      end else if (done_off) begin
        stop <= 1'b1;
        pend <= PEND_NONE;
      end else if (done_on) begin
        stop <= 1'b0;
        pend <= PEND_NONE;
      end else if (hit_off1) begin
        pend <= PEND_XOFF;
      end else if (hit_on1) begin
        pend <= PEND_XON;
      end else begin
        pend <= PEND_NONE;
      end
    end
  end
endmodule

// File: rtl/fc_tx_insert.sv
module fc_tx_insert
  import flow_ctrl_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              dual,
  input  logic              flush,
  input  logic [LVL_W-1:0]  level,
  input  logic [LVL_W-1:0]  hi_thr,
  input  logic [LVL_W-1:0]  lo_thr,
  input  logic [CHAR_W-1:0] xon1,
  input  logic [CHAR_W-1:0] xon2,
  input  logic [CHAR_W-1:0] xoff1,
  input  logic [CHAR_W-1:0] xoff2,
  input  logic              ins_ready,
  output logic              ins_valid,
  output logic [CHAR_W-1:0] ins_data
);
  ins_state_t state;
  logic       is_xoff;
  logic       xoff_out;

  assign ins_valid = (state != INS_IDLE);

  always_comb begin
    ins_data = '0;
    if (state == INS_FIRST)  ins_data = is_xoff ? xoff1 : xon1;
    if (state == INS_SECOND) ins_data = is_xoff ? xoff2 : xon2;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= INS_IDLE;
      is_xoff  <= 1'b0;
      xoff_out <= 1'b0;
    end else begin
      unique case (state)
        INS_IDLE: begin
          if (flush) begin
            xoff_out <= 1'b0;
          end else if (en && !xoff_out && level >= hi_thr) begin
            state    <= INS_FIRST;
            is_xoff  <= 1'b1;
            xoff_out <= 1'b1;
          end else if (en && xoff_out && level <= lo_thr) begin
            state    <= INS_FIRST;
            is_xoff  <= 1'b0;
            xoff_out <= 1'b0;
          end
        end
        INS_FIRST: begin
          if (flush) xoff_out <= 1'b0;
          if (ins_ready) state <= dual ? INS_SECOND : INS_IDLE;
        end
        INS_SECOND: begin
          if (flush) xoff_out <= 1'b0;
          if (ins_ready) state <= INS_IDLE;
        end
        default: state <= INS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flow_ctrl_engine.sv
module flow_ctrl_engine #(
  parameter int CHAR_W      = 8,
  parameter int LVL_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_auto_cts,
  input  logic              cfg_auto_rts,
  input  logic              cfg_swap_dsr_dtr,
  input  logic              cfg_sw_rx_en,
  input  logic              cfg_sw_tx_en,
  input  logic              cfg_sw_dual,
  input  logic [LVL_W-1:0]  cfg_hi_thr,
  input  logic [LVL_W-1:0]  cfg_lo_thr,
  input  logic [CHAR_W-1:0] cfg_xon1,
  input  logic [CHAR_W-1:0] cfg_xon2,
  input  logic [CHAR_W-1:0] cfg_xoff1,
  input  logic [CHAR_W-1:0] cfg_xoff2,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_flush,
  input  logic              rx_valid,
  input  logic [CHAR_W-1:0] rx_data,
  output logic              rx_drop,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              man_rts_n,
  input  logic              man_dtr_n,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              tx_hold,
  output logic              ins_valid,
  input  logic              ins_ready,
  output logic [CHAR_W-1:0] ins_data
);
  logic cts_s, dsr_s, flow_in;
  logic fill_stop, flow_out;
  logic remote_stop;

  fc_sync #(.STAGES(SYNC_STAGES)) u_sync_cts (.clk(clk), .rst_n(rst_n), .d(cts_n), .q(cts_s));
  fc_sync #(.STAGES(SYNC_STAGES)) u_sync_dsr (.clk(clk), .rst_n(rst_n), .d(dsr_n), .q(dsr_s));

  assign flow_in = cfg_swap_dsr_dtr ? dsr_s : cts_s;

  // Hysteresis on fill level: high mark wins if both marks are met.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       fill_stop <= 1'b0;
    else if (rx_level >= cfg_hi_thr)  fill_stop <= 1'b1;
    else if (rx_level <= cfg_lo_thr)  fill_stop <= 1'b0;
  end

  assign flow_out = cfg_auto_rts ? fill_stop : (cfg_swap_dsr_dtr ? man_dtr_n : man_rts_n);
  assign rts_n    = cfg_swap_dsr_dtr ? man_rts_n : flow_out;
  assign dtr_n    = cfg_swap_dsr_dtr ? flow_out  : man_dtr_n;

  fc_rx_match #(.CHAR_W(CHAR_W)) u_rx_match (
    .clk(clk), .rst_n(rst_n), .en(cfg_sw_rx_en), .dual(cfg_sw_dual),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .xon1(cfg_xon1), .xon2(cfg_xon2), .xoff1(cfg_xoff1), .xoff2(cfg_xoff2),
    .drop(rx_drop), .stop(remote_stop)
  );

  fc_tx_insert #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) u_tx_insert (
    .clk(clk), .rst_n(rst_n), .en(cfg_sw_tx_en), .dual(cfg_sw_dual),
    .flush(rx_flush), .level(rx_level), .hi_thr(cfg_hi_thr), .lo_thr(cfg_lo_thr),
    .xon1(cfg_xon1), .xon2(cfg_xon2), .xoff1(cfg_xoff1), .xoff2(cfg_xoff2),
    .ins_ready(ins_ready), .ins_valid(ins_valid), .ins_data(ins_data)
  );

  assign tx_hold = (cfg_auto_cts && flow_in) || (cfg_sw_rx_en && remote_stop);
endmodule

// File: rtl/flow_ctrl_checker.sv
module flow_ctrl_checker #(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_auto_cts,
  input logic              cfg_auto_rts,
  input logic              cfg_swap_dsr_dtr,
  input logic              cfg_sw_rx_en,
  input logic              cfg_sw_dual,
  input logic [LVL_W-1:0]  cfg_hi_thr,
  input logic [LVL_W-1:0]  cfg_lo_thr,
  input logic [CHAR_W-1:0] cfg_xoff1,
  input logic [LVL_W-1:0]  rx_level,
  input logic              rx_valid,
  input logic [CHAR_W-1:0] rx_data,
  input logic              rx_drop,
  input logic              rts_n,
  input logic              tx_hold,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic [CHAR_W-1:0] ins_data
);
  p_ins_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !ins_ready) |=> (ins_valid && $stable(ins_data)));

  p_drop_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_drop |-> rx_valid);

  p_rts_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level >= cfg_hi_thr) |=> (!cfg_auto_rts || cfg_swap_dsr_dtr || rts_n));

  p_rts_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_level <= cfg_lo_thr && rx_level < cfg_hi_thr) |=>
      (!cfg_auto_rts || cfg_swap_dsr_dtr || !rts_n));

  p_single_xoff_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_sw_rx_en && rx_data == cfg_xoff1) |-> rx_drop);

  p_single_xoff_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && cfg_sw_rx_en && !cfg_sw_dual && rx_data == cfg_xoff1) |=>
      (tx_hold || !cfg_sw_rx_en));

  p_no_hold_source_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_auto_cts && !cfg_sw_rx_en) |-> !tx_hold);

  p_no_drop_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_sw_rx_en |-> !rx_drop);
endmodule

bind flow_ctrl_engine flow_ctrl_checker #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) chk_i (.*);

// File: tb/flow_ctrl_engine_tb_top.sv
module flow_ctrl_engine_tb_top;
  localparam int CW = 8;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_auto_cts = 0, cfg_auto_rts = 0, cfg_swap_dsr_dtr = 0;
  logic cfg_sw_rx_en = 0, cfg_sw_tx_en = 0, cfg_sw_dual = 0;
  logic [LW-1:0] cfg_hi_thr = 8'd8, cfg_lo_thr = 8'd3;
  logic [CW-1:0] cfg_xon1 = 8'h11, cfg_xon2 = 8'h12, cfg_xoff1 = 8'h13, cfg_xoff2 = 8'h14;
  logic [LW-1:0] rx_level = '0;
  logic rx_flush = 0, rx_valid = 0;
  logic [CW-1:0] rx_data = '0;
  logic rx_drop;
  logic cts_n = 0, dsr_n = 0, man_rts_n = 0, man_dtr_n = 1;
  logic rts_n, dtr_n, tx_hold, ins_valid;
  logic ins_ready = 1;
  logic [CW-1:0] ins_data;

  int n_checks = 0;
  int n_errors = 0;
  logic [CW-1:0] exp_q[$];

  always #4 clk = ~clk;

  flow_ctrl_engine #(.CHAR_W(CW), .LVL_W(LW), .SYNC_STAGES(2)) dut_i (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send_rx(logic [CW-1:0] d, logic exp_drop, string req);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = d;
    #1;
    chk(req, rx_drop, exp_drop);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  // Monitor: compares each accepted insert character with the scoreboard.
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && ins_valid && ins_ready) begin
        n_checks++;
        if (exp_q.size() == 0) begin
          n_errors++;
          $display("FAIL R4,R5,R6: actual %0h expected none", ins_data);
        end else begin
          logic [CW-1:0] e;
          e = exp_q.pop_front();
          if (ins_data !== e) begin
            n_errors++;
            $display("FAIL R4,R5,R6: actual %0h expected %0h", ins_data, e);
          end
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    chk("reset rts_n", rts_n, 0);
    chk("reset dtr_n", dtr_n, 1);
    chk("reset tx_hold", tx_hold, 0);
    chk("reset ins_valid", ins_valid, 0);
    chk("reset rx_drop", rx_drop, 0);

    // R1: clear-to-send pause through synchroniser
    cfg_auto_cts = 1; cts_n = 1;
    wait_n(2); chk("R1 hold on", tx_hold, 1);
    cts_n = 0;
    wait_n(2); chk("R1 release", tx_hold, 0);

    // R12: clear-to-send ignored when disabled
    cfg_auto_cts = 0; cts_n = 1;
    wait_n(3); chk("R12 cts ignored", tx_hold, 0);
    cts_n = 0;

    // R2: remap onto dsr_n / dtr_n
    cfg_auto_cts = 1; cfg_swap_dsr_dtr = 1; cts_n = 1;
    wait_n(3); chk("R2 cts ignored when remapped", tx_hold, 0);
    dsr_n = 1;
    wait_n(2); chk("R2 dsr pauses", tx_hold, 1);
    dsr_n = 0; cts_n = 0;
    wait_n(2);
    cfg_auto_rts = 1; rx_level = 9;
    wait_n(1);
    chk("R2 dtr carries flow", dtr_n, 1);
    chk("R2 rts manual", rts_n, 0);
    rx_level = 0;
    wait_n(1); chk("R2 dtr reasserted", dtr_n, 0);
    cfg_swap_dsr_dtr = 0;

    // R3: hysteresis
    rx_level = 7; wait_n(1); chk("R3 below high", rts_n, 0);
    rx_level = 8; wait_n(1); chk("R3 at high", rts_n, 1);
    rx_level = 5; wait_n(1); chk("R3 in band", rts_n, 1);
    rx_level = 3; wait_n(1); chk("R3 at low", rts_n, 0);
    cfg_auto_rts = 0; man_rts_n = 1;
    wait_n(1); chk("R3 manual", rts_n, 1);
    man_rts_n = 0;

    // R4, R5, R6 single character
    cfg_sw_tx_en = 1;
    rx_level = 8; exp_q.push_back(8'h13);
    wait_n(4); chk("R4 one xoff only", ins_valid, 0);
    rx_level = 5; wait_n(3); chk("R5 nothing in band", ins_valid, 0);
    rx_level = 3; exp_q.push_back(8'h11);
    wait_n(4);
    chk("R5 xon drained", exp_q.size(), 0);

    // R6 dual pairs
    cfg_sw_dual = 1;
    rx_level = 9; exp_q.push_back(8'h13); exp_q.push_back(8'h14);
    wait_n(5);
    rx_level = 2; exp_q.push_back(8'h11); exp_q.push_back(8'h12);
    wait_n(5);
    chk("R6 pairs drained", exp_q.size(), 0);

    // R7: stalled insert while transmitter paused
    cts_n = 1; ins_ready = 0;
    rx_level = 9; exp_q.push_back(8'h13); exp_q.push_back(8'h14);
    wait_n(2);
    chk("R7 offered", ins_valid, 1);
    chk("R7 data", ins_data, 8'h13);
    wait_n(3);
    chk("R7 still offered", ins_valid, 1);
    chk("R7 data stable", ins_data, 8'h13);
    chk("R7 paused at same time", tx_hold, 1);
    ins_ready = 1;
    wait_n(4);
    chk("R7 drained", exp_q.size(), 0);
    cts_n = 0;
    wait_n(2);

    // R11: flush forgets the outstanding xoff
    rx_flush = 1; rx_level = 0;
    wait_n(1); rx_flush = 0;
    wait_n(4); chk("R11 no xon after flush", ins_valid, 0);
    rx_level = 9; exp_q.push_back(8'h13); exp_q.push_back(8'h14);
    wait_n(5);
    rx_level = 0; exp_q.push_back(8'h11); exp_q.push_back(8'h12);
    wait_n(5);
    chk("R11 drained", exp_q.size(), 0);
    cfg_sw_tx_en = 0; cfg_sw_dual = 0; cfg_auto_cts = 0;

    // R8 single recognition
    cfg_sw_rx_en = 1;
    send_rx(8'h41, 0, "R8 data passes");
    chk("R8 no hold on data", tx_hold, 0);
    send_rx(8'h13, 1, "R8 xoff dropped");
    chk("R8 xoff holds", tx_hold, 1);
    send_rx(8'h11, 1, "R8 xon dropped");
    chk("R8 xon releases", tx_hold, 0);

    // R9 dual recognition
    cfg_sw_dual = 1;
    send_rx(8'h13, 1, "R9 xoff1 dropped");
    chk("R9 half pair no hold", tx_hold, 0);
    send_rx(8'h14, 1, "R9 xoff2 dropped");
    chk("R9 pair holds", tx_hold, 1);
    send_rx(8'h11, 1, "R9 xon1 dropped");
    chk("R9 half xon keeps hold", tx_hold, 1);
    send_rx(8'h12, 1, "R9 xon2 dropped");
    chk("R9 pair releases", tx_hold, 0);

    // R10 broken pair and orphan second character
    send_rx(8'h13, 1, "R10 xoff1 dropped");
    send_rx(8'h41, 0, "R10 data passes");
    send_rx(8'h14, 0, "R10 orphan xoff2 passes");
    chk("R10 no hold", tx_hold, 0);

    // R12 software receive disabled
    cfg_sw_rx_en = 0; cfg_sw_dual = 0;
    send_rx(8'h13, 0, "R12 no drop when disabled");
    chk("R12 no hold when disabled", tx_hold, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule